// File: doc/BRIEF.md
# K-line fast-init wake-up generator

This block produces the wake-up waveform that opens a fast-initialisation exchange on a diagnostic K line, an L line, or both. A one-cycle start request carries a two-bit line select. Each chosen line is pulled low for a fixed low phase, measured from the moment the request is accepted. While a line is held low, it is lifted high for a single clock cycle at a regular interval. These keep-alive pulses stop a bus transceiver's dominant time-out from cutting the driver off.

When the low phase ends, each chosen line goes back to its UART transmit path, which idles high. The block stays busy until the full wake-up window has elapsed since the start, then raises done for one cycle, so that the first message can go out at the right moment. A line that was not selected stays on its UART path for the whole sequence.

All timing comes from one free-running microsecond timebase. The clocks-per-microsecond ratio is a parameter, and so are the low phase, the keep-alive interval and the window, all given in microseconds.

Top module: `kline_wake_gen`

## Requirements
- R1: `sel_i` chooses the lines that are driven: value 0 = K line only, 1 = L line only, 2 = both lines. A line that is not chosen is never pulled low.
- R2: On the clock edge that accepts a start, the state changes. Each chosen line output reads low from the following edge onward.
- R3: The low phase lasts LOW_US microseconds from the start, within the one-microsecond step of the timebase. Counting from the first low cycle to the first cycle of release, with C = CLK_PER_US, it spans between (LOW_US-1)*C+1 and LOW_US*C clock cycles.
- R4: During the low phase, each chosen line rises for exactly one clock cycle every KEEP_US microseconds. Successive pulses are exactly KEEP_US*C cycles apart. A pulse that would coincide with the end of the low phase is replaced by the release, so the phase contains (LOW_US-1)/KEEP_US pulses.
- R5: After the low phase, each chosen line follows its own UART transmit input again, with one register stage.
- R6: A line that is not chosen, and every line while idle, equals its UART transmit input as sampled on the previous clock edge.
- R7: `busy_o` is high from the edge that accepts a start until WINDOW_US microseconds have passed since that start. This gives between (WINDOW_US-1)*C+1 and WINDOW_US*C cycles of busy.
- R8: `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low after a sequence. At no other time is it high.
- R9: A start request with `sel_i` = 3 while idle raises `sel_err_o` for one cycle. It starts no sequence, so `busy_o` stays low.
- R10: A start request of any select value while busy is ignored. The running sequence keeps its timing and lines, and `sel_err_o` stays low.
- R11: While reset is high, and directly after it, `busy_o`, `done_o` and `sel_err_o` are low and both line outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle wake-up request |
| sel_i | input | 2 | Line select: 0 K, 1 L, 2 both, 3 invalid |
| k_uart_tx_i | input | 1 | UART transmit output destined for the K line |
| l_uart_tx_i | input | 1 | UART transmit output destined for the L line |
| k_line_o | output | 1 | Registered K line drive |
| l_line_o | output | 1 | Registered L line drive |
| busy_o | output | 1 | Wake-up window in progress |
| done_o | output | 1 | One-cycle pulse at the end of the window |
| sel_err_o | output | 1 | One-cycle pulse for a rejected select code |

## Verification
Sequences are run with each of the three valid select codes, in both directed and random order. For each sequence, the chosen line's waveform is split into its low phase, its keep-alive pulses, their spacing and the release point. Throughout every sequence, the line that was not chosen is driven with random UART data. Any leak of the wake-up pattern onto that line, or any swap between K and L, then shows as a mismatch.

Some sequences receive a second start request in the middle, sometimes carrying the invalid code. A restart or a false error then shows up as a stretched busy window or as a pulse on `sel_err_o`. The invalid code is also tried while idle, to separate its rejection from a real start. Between sequences, both UART inputs toggle at random, which confirms that the lines pass data through with a one-cycle delay.

// File: rtl/kline_wake_pkg.sv
package kline_wake_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HOLD = 2'd2
  } wake_state_e;

  localparam logic [1:0] SEL_K    = 2'd0;
  localparam logic [1:0] SEL_L    = 2'd1;
  localparam logic [1:0] SEL_BOTH = 2'd2;
  localparam logic [1:0] SEL_BAD  = 2'd3;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_K    = 0;
  localparam int unsigned LINE_L    = 1;

  // Bit LINE_K set drives the K line, bit LINE_L drives the L line.
  function automatic logic [NUM_LINES-1:0] lane_mask(input logic [1:0] sel);
    logic [NUM_LINES-1:0] m;
    m = '0;
    case (sel)
      SEL_K:    m[LINE_K] = 1'b1;
      SEL_L:    m[LINE_L] = 1'b1;
      SEL_BOTH: m = '1;
      default:  m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/kline_us_timebase.sv
module kline_us_timebase #(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned US_W       = 17
) (
  input  logic            clk,
  input  logic            rst,
  output logic [US_W-1:0] us_cnt_o
);

  logic tick;

  generate
    if (CLK_PER_US > 1) begin : g_div
      localparam int unsigned PRE_W = $clog2(CLK_PER_US);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end

      assign tick = (pre_q == PRE_LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  // Free-running microsecond count; wraps, consumers use modular differences.
  always_ff @(posedge clk) begin
    if (rst) begin
      us_cnt_o <= '0;
    end else if (tick) begin
      us_cnt_o <= us_cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/kline_wake_ctrl.sv
module kline_wake_ctrl
  import kline_wake_pkg::*;
#(
  parameter int unsigned LOW_US    = 25000,
  parameter int unsigned KEEP_US   = 5000,
  parameter int unsigned WINDOW_US = 49000,
  parameter int unsigned US_W      = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [1:0]           sel_i,
  input  logic [US_W-1:0]      us_cnt_i,
  output logic [NUM_LINES-1:0] drive_mask_o,
  output logic                 pulse_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sel_err_o
);

  localparam logic [US_W-1:0] LOW_T  = US_W'(LOW_US);
  localparam logic [US_W-1:0] KEEP_T = US_W'(KEEP_US);
  localparam logic [US_W-1:0] WIN_T  = US_W'(WINDOW_US);

  wake_state_e     state_q;
  logic [US_W-1:0] start_stamp_q;
  logic [US_W-1:0] keep_stamp_q;
  logic [US_W-1:0] since_start;
  logic [US_W-1:0] since_keep;

  assign since_start = us_cnt_i - start_stamp_q;
  assign since_keep  = us_cnt_i - keep_stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      start_stamp_q <= '0;
      keep_stamp_q  <= '0;
      drive_mask_o  <= '0;
      pulse_o       <= 1'b0;
      busy_o        <= 1'b0;
      done_o        <= 1'b0;
      sel_err_o     <= 1'b0;
    end else begin
      pulse_o   <= 1'b0;
      done_o    <= 1'b0;
      sel_err_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (sel_i == SEL_BAD) begin
              sel_err_o <= 1'b1;
            end else begin
              state_q       <= ST_LOW;
              busy_o        <= 1'b1;
              start_stamp_q <= us_cnt_i;
              keep_stamp_q  <= us_cnt_i;
              drive_mask_o  <= lane_mask(sel_i);
            end
          end
        end
        ST_LOW: begin
          // Release wins over a keep-alive pulse falling on the same microsecond.
          if (since_start >= LOW_T) begin
            state_q      <= ST_HOLD;
            drive_mask_o <= '0;
          end else if (since_keep >= KEEP_T) begin
            pulse_o      <= 1'b1;
            keep_stamp_q <= us_cnt_i;
          end
        end
        ST_HOLD: begin
          if (since_start >= WIN_T) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
          end
        end
        default: begin
          state_q      <= ST_IDLE;
          busy_o       <= 1'b0;
          drive_mask_o <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/kline_line_drive.sv
module kline_line_drive #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] drive_mask_i,
  input  logic             pulse_i,
  input  logic [LINES-1:0] uart_tx_i,
  output logic [LINES-1:0] line_o
);

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          line_o[g] <= 1'b1;
        end else if (drive_mask_i[g]) begin
          line_o[g] <= pulse_i;
        end else begin
          line_o[g] <= uart_tx_i[g];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/kline_wake_gen.sv
module kline_wake_gen
  import kline_wake_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned LOW_US     = 25000,
  parameter int unsigned KEEP_US    = 5000,
  parameter int unsigned WINDOW_US  = 49000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  input  logic       k_uart_tx_i,
  input  logic       l_uart_tx_i,
  output logic       k_line_o,
  output logic       l_line_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       sel_err_o
);

  localparam int unsigned US_W = $clog2(WINDOW_US + 1) + 1;

  logic [US_W-1:0]      us_cnt;
  logic [NUM_LINES-1:0] drive_mask;
  logic                 pulse;
  logic [NUM_LINES-1:0] uart_tx;
  logic [NUM_LINES-1:0] line;

  assign uart_tx[LINE_K] = k_uart_tx_i;
  assign uart_tx[LINE_L] = l_uart_tx_i;
  assign k_line_o        = line[LINE_K];
  assign l_line_o        = line[LINE_L];

  kline_us_timebase #(
    .CLK_PER_US (CLK_PER_US),
    .US_W       (US_W)
  ) u_timebase (
    .clk      (clk),
    .rst      (rst),
    .us_cnt_o (us_cnt)
  );

  kline_wake_ctrl #(
    .LOW_US    (LOW_US),
    .KEEP_US   (KEEP_US),
    .WINDOW_US (WINDOW_US),
    .US_W      (US_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .sel_i        (sel_i),
    .us_cnt_i     (us_cnt),
    .drive_mask_o (drive_mask),
    .pulse_o      (pulse),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .sel_err_o    (sel_err_o)
  );

  kline_line_drive #(
    .LINES (NUM_LINES)
  ) u_drive (
    .clk          (clk),
    .rst          (rst),
    .drive_mask_i (drive_mask),
    .pulse_i      (pulse),
    .uart_tx_i    (uart_tx),
    .line_o       (line)
  );

endmodule

// File: rtl/kline_wake_chk.sv
module kline_wake_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic k_uart_tx_i,
  input logic l_uart_tx_i,
  input logic k_line_o,
  input logic l_line_o,
  input logic busy_o,
  input logic done_o,
  input logic sel_err_o
);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_err_idle_R9: assert property (@(posedge clk) disable iff (rst)
    sel_err_o |-> (!busy_o && !$past(busy_o)));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !sel_err_o);

  assert_idle_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o) && !$past(rst)) |->
      (k_line_o == $past(k_uart_tx_i) && l_line_o == $past(l_uart_tx_i)));

endmodule

bind kline_wake_gen kline_wake_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .k_uart_tx_i (k_uart_tx_i),
  .l_uart_tx_i (l_uart_tx_i),
  .k_line_o    (k_line_o),
  .l_line_o    (l_line_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sel_err_o   (sel_err_o)
);

// File: tb/kline_wake_gen_bench.sv
`timescale 1ns/1ps
module kline_wake_gen_bench;

  localparam int C    = 4;
  localparam int LOW  = 25;
  localparam int KEEP = 5;
  localparam int WIN  = 49;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic k_tx = 1'b1;
  logic l_tx = 1'b1;
  logic k_line_o, l_line_o, busy_o, done_o, sel_err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  kline_wake_gen #(
    .CLK_PER_US (C),
    .LOW_US     (LOW),
    .KEEP_US    (KEEP),
    .WINDOW_US  (WIN)
  ) u_kline_wake_gen (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .sel_i       (sel_i),
    .k_uart_tx_i (k_tx),
    .l_uart_tx_i (l_tx),
    .k_line_o    (k_line_o),
    .l_line_o    (l_line_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .sel_err_o   (sel_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_mask(input logic [1:0] sel);
    case (sel)
      2'd0: return 2'b01;
      2'd1: return 2'b10;
      2'd2: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // Idle cycles with random UART data; both lines must pass it through (R6).
  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      check(k_line_o == k_tx, "R6 idle K", int'(k_line_o), int'(k_tx));
      check(l_line_o == l_tx, "R6 idle L", int'(l_line_o), int'(l_tx));
      check(!busy_o && !done_o && !sel_err_o, "R11/R8 idle flags",
            int'({busy_o, done_o, sel_err_o}), 0);
      k_tx = 1'($urandom);
      l_tx = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic analyse(input logic [511:0] v, input int last, input string nm);
    int r = -1;
    int pcnt = 0;
    int prev = -1;
    check(v[1] == 1'b0, {"R2 first low ", nm}, int'(v[1]), 0);
    for (int i = 1; i < last; i++) begin
      if (r < 0 && v[i] && v[i+1]) r = i;
    end
    check(r > 0, {"R3 release found ", nm}, r, 1);
    if (r > 0) begin
      check((r - 1) >= (LOW-1)*C + 1 && (r - 1) <= LOW*C, {"R3 low length ", nm},
            r - 1, LOW*C);
      for (int i = 1; i < r; i++) begin
        if (v[i]) begin
          pcnt++;
          if (prev >= 0) check(i - prev == KEEP*C, {"R4 pulse spacing ", nm}, i - prev, KEEP*C);
          prev = i;
        end
      end
      check(pcnt == (LOW-1)/KEEP, {"R4 pulse count ", nm}, pcnt, (LOW-1)/KEEP);
      for (int i = r; i <= last; i++) begin
        if (!v[i]) check(1'b0, {"R5 released line high ", nm}, 0, 1);
      end
    end
  endtask

  task automatic run_seq(input logic [1:0] sel, input bit inject);
    logic [1:0] m;
    logic [511:0] kv = '0;
    logic [511:0] lv = '0;
    int n = 0;
    int busy_cnt = 0;
    int inj_at;
    m = exp_mask(sel);
    inj_at = 5 + int'($urandom % 150);
    k_tx = m[0] ? 1'b1 : 1'($urandom);
    l_tx = m[1] ? 1'b1 : 1'($urandom);
    sel_i = sel;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R7 busy after start", int'(busy_o), 1);
    while (n < 500) begin
      kv[n] = k_line_o;
      lv[n] = l_line_o;
      if (!m[0]) check(k_line_o == k_tx, "R1/R6 unselected K follows UART", int'(k_line_o), int'(k_tx));
      if (!m[1]) check(l_line_o == l_tx, "R1/R6 unselected L follows UART", int'(l_line_o), int'(l_tx));
      check(!sel_err_o, "R10 no error while busy", int'(sel_err_o), 0);
      if (busy_o) begin
        busy_cnt++;
        check(!done_o, "R8 done low while busy", int'(done_o), 0);
      end else begin
        check(done_o, "R8 done as busy clears", int'(done_o), 1);
        break;
      end
      k_tx = m[0] ? 1'b1 : 1'($urandom);
      l_tx = m[1] ? 1'b1 : 1'($urandom);
      start_i = inject && (n == inj_at);
      sel_i = 2'($urandom);
      n++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(busy_cnt >= (WIN-1)*C + 1 && busy_cnt <= WIN*C, "R7 busy length", busy_cnt, WIN*C);
    if (m[0]) analyse(kv, n, "K");
    if (m[1]) analyse(lv, n, "L");
    @(negedge clk);
    check(!done_o, "R8 done one cycle", int'(done_o), 0);
    check(!busy_o, "R10 no restart", int'(busy_o), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !sel_err_o, "R11 reset flags",
          int'({busy_o, done_o, sel_err_o}), 0);
    check(k_line_o && l_line_o, "R11 reset lines high", int'({k_line_o, l_line_o}), 3);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && k_line_o && l_line_o, "R11 after reset",
          int'({busy_o, k_line_o, l_line_o}), 3);
    idle_cycles(10);

    // R9: invalid select while idle
    sel_i = 2'd3;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(sel_err_o == 1'b1, "R9 error pulse", int'(sel_err_o), 1);
    check(busy_o == 1'b0, "R9 no sequence", int'(busy_o), 0);
    @(negedge clk);
    check(sel_err_o == 1'b0, "R9 error one cycle", int'(sel_err_o), 0);
    check(busy_o == 1'b0, "R9 still idle", int'(busy_o), 0);
    idle_cycles(5);

    // Directed: each select code (R1), then a start injected while busy (R10)
    run_seq(2'd0, 1'b0);
    idle_cycles(7);
    run_seq(2'd1, 1'b0);
    idle_cycles(7);
    run_seq(2'd2, 1'b0);
    idle_cycles(7);
    run_seq(2'd0, 1'b1);
    idle_cycles(4);

    for (int s = 0; s < 14; s++) begin
      run_seq(2'($urandom % 3), 1'($urandom));
      idle_cycles(3 + int'($urandom % 15));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

endmodule